// File: doc/BRIEF.md
# Half to Single Precision Widening Converter

This block takes a 16-bit half-precision value and returns the 32-bit single-precision value that represents the same number exactly. No rounding is ever needed, because every half-precision value fits in single precision. The result and an invalid-operation flag are registered, so they appear one clock after the input is presented.

A select input chooses how the top half-precision exponent code (all ones) is read. In standard IEEE mode that code stands for infinity or NaN. In the extended-range mode there are no special encodings: the all-ones exponent is an ordinary normal exponent, so the largest magnitudes are twice as large. Subnormal half inputs are normalized with a leading-zero count, so they become normal single-precision numbers. Signaling NaNs are quieted, and they raise the invalid flag.

Top module: `h2s_convert`

## Requirements
- R1: Input bit 15 is the sign, bits 14:10 are the exponent and bits 9:0 are the fraction. For an exponent from 1 to 30, in either mode, the result has the same sign, exponent field (bits 30:23) equal to the input exponent plus 112, the fraction in bits 22:13 and zeros in bits 12:0.
- R2: An input with exponent 0 and fraction 0 gives a signed zero: bit 31 equals the input sign and bits 30:0 are zero.
- R3: When ieee_sel is 1, exponent 31 with fraction 0 gives infinity: the same sign, exponent field 0xFF and fraction 0.
- R4: When ieee_sel is 1, exponent 31 with a nonzero fraction gives a quiet NaN. It keeps the sign, has exponent field 0xFF and bit 22 set, takes input fraction bits 8:0 into result bits 21:13, and has zeros in bits 12:0.
- R5: A NaN is signaling when input fraction bit 9 is 0. In that case invalid_out is 1 and the result is as in R4. For every other input, in both modes, invalid_out is 0.
- R6: When ieee_sel is 0, exponent 31 is a normal exponent. The result has exponent field 143, the input fraction in bits 22:13, and invalid_out is 0. In this mode the result exponent field is never 0xFF.
- R7: An input with exponent 0 and a nonzero fraction is subnormal. If z is the number of leading zeros of the 10-bit fraction, the result has exponent field 112 - z, and its fraction is the input fraction shifted left by z+1 and truncated to 10 bits, placed in bits 22:13. The result value equals the input value exactly.
- R8: Outputs are registered with a latency of one cycle, and they do not change before the next rising edge. While rst_n is low, single_out and invalid_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_in | input | 16 | Half-precision operand |
| ieee_sel | input | 1 | 1: IEEE half format, 0: extended-range half format |
| single_out | output | 32 | Single-precision result, one cycle later |
| invalid_out | output | 1 | Invalid-operation flag (signaling NaN), one cycle later |

## Verification
A table of hand-derived vectors sets the classes apart from one another:
- the top normal value against the all-ones exponent, in each mode;
- the largest subnormal against the smallest normal;
- a quiet NaN against a signaling NaN, with a payload that shows whether fraction bits are moved.

After the table, every one of the 65536 codes is run in both modes against a behavioural model. That model normalizes subnormals by shifting one bit at a time rather than by counting leading zeros. Directed steps check the reset value and show that the output holds until the clock edge.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HALF_W      = 16;
  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int HALF_BIAS   = 15;
  localparam int SGL_W       = 32;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = 23;
  localparam int SGL_BIAS    = 127;
  localparam int REBIAS      = SGL_BIAS - HALF_BIAS;
  localparam int LZ_W        = $clog2(HALF_FRAC_W + 1);
  localparam int PAD_W       = SGL_FRAC_W - HALF_FRAC_W;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } h2s_class_e;

  // Leading zeros of a fraction field; returns the width when all bits are zero.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [HALF_FRAC_W-1:0] f);
    logic [LZ_W-1:0] n;
    n = LZ_W'(HALF_FRAC_W);
    for (int i = 0; i < HALF_FRAC_W; i++)
      if (f[i]) n = LZ_W'(HALF_FRAC_W - 1 - i);
    return n;
  endfunction

  // Re-biased exponent for a normal operand.
  function automatic logic [SGL_EXP_W-1:0] rebias_exp(input logic [HALF_EXP_W-1:0] e);
    return SGL_EXP_W'(e) + SGL_EXP_W'(REBIAS);
  endfunction
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0]      half_i,
  input  logic                   ieee_i,
  output logic                   sign_o,
  output logic [HALF_EXP_W-1:0]  exp_o,
  output logic [HALF_FRAC_W-1:0] frac_o,
  output h2s_class_e             cls_o
);
  localparam logic [HALF_EXP_W-1:0] EXP_TOP = '1;

  logic frac_nz, exp_top, exp_zero;

  assign sign_o   = half_i[HALF_W-1];
  assign exp_o    = half_i[HALF_W-2 -: HALF_EXP_W];
  assign frac_o   = half_i[HALF_FRAC_W-1:0];
  assign frac_nz  = |frac_o;
  assign exp_top  = (exp_o == EXP_TOP) && ieee_i;
  assign exp_zero = (exp_o == '0);

  always_comb begin
    if (exp_top && !frac_nz)              cls_o = CLS_INF;
    else if (exp_top && frac_o[HALF_FRAC_W-1]) cls_o = CLS_QNAN;
    else if (exp_top)                     cls_o = CLS_SNAN;
    else if (exp_zero && !frac_nz)        cls_o = CLS_ZERO;
    else if (exp_zero)                    cls_o = CLS_SUB;
    else                                  cls_o = CLS_NORM;
  end

  // Extended-range mode never yields a special class (R6).
  always_comb begin
    if (ieee_i === 1'b0)
      a_alt_no_special_r6: assert (cls_o != CLS_INF && cls_o != CLS_QNAN && cls_o != CLS_SNAN);
  end
endmodule

// File: rtl/h2s_normalize.sv
module h2s_normalize
  import h2s_pkg::*;
(
  input  logic [HALF_FRAC_W-1:0] frac_i,
  output logic [SGL_EXP_W-1:0]   exp_o,
  output logic [HALF_FRAC_W-1:0] frac_o
);
  logic [LZ_W-1:0]        lz;
  logic [HALF_FRAC_W:0]   shifted;

  assign lz      = lead_zeros(frac_i);
  assign shifted = {1'b0, frac_i} << (lz + LZ_W'(1));
  assign exp_o   = SGL_EXP_W'(REBIAS) - SGL_EXP_W'(lz);
  assign frac_o  = shifted[HALF_FRAC_W-1:0];

  // The hidden one must land just above the kept fraction (R7).
  always_comb begin
    if (frac_i !== '0 && !$isunknown(frac_i))
      a_norm_hidden_one_r7: assert (shifted[HALF_FRAC_W] == 1'b1);
  end
endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
  import h2s_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       half_in,
  input  logic              ieee_sel,
  output logic [31:0]       single_out,
  output logic              invalid_out
);
  localparam logic [SGL_EXP_W-1:0] SEXP_TOP = '1;

  logic                   sgn;
  logic [HALF_EXP_W-1:0]  hexp;
  logic [HALF_FRAC_W-1:0] hfrac;
  h2s_class_e             cls;
  logic [SGL_EXP_W-1:0]   sub_exp;
  logic [HALF_FRAC_W-1:0] sub_frac;
  logic [SGL_W-1:0]       result_c;
  logic                   invalid_c;

  h2s_classify u_cls (
    .half_i (half_in), .ieee_i (ieee_sel),
    .sign_o (sgn), .exp_o (hexp), .frac_o (hfrac), .cls_o (cls)
  );

  h2s_normalize u_norm (
    .frac_i (hfrac), .exp_o (sub_exp), .frac_o (sub_frac)
  );

  always_comb begin
    invalid_c = 1'b0;
    unique case (cls)
      CLS_ZERO: result_c = {sgn, {(SGL_W-1){1'b0}}};
      CLS_SUB:  result_c = {sgn, sub_exp, sub_frac, {PAD_W{1'b0}}};
      CLS_INF:  result_c = {sgn, SEXP_TOP, {SGL_FRAC_W{1'b0}}};
      CLS_QNAN,
      CLS_SNAN: begin
        result_c  = {sgn, SEXP_TOP, 1'b1, hfrac[HALF_FRAC_W-2:0], {PAD_W{1'b0}}};
        invalid_c = (cls == CLS_SNAN);
      end
      default:  result_c = {sgn, rebias_exp(hexp), hfrac, {PAD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_out  <= '0;
      invalid_out <= 1'b0;
    end else begin
      single_out  <= result_c;
      invalid_out <= invalid_c;
    end
  end

  p_invalid_is_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_out |-> (single_out[30:23] == SEXP_TOP) && single_out[22]);

  p_nan_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (single_out[30:23] == SEXP_TOP) && (single_out[22:0] != '0) |-> single_out[22]);

  p_sign_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> single_out[31] == $past(half_in[15]));

  p_alt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ieee_sel |=> (single_out[30:23] != SEXP_TOP) && !invalid_out);

  p_signed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_in[14:0] == '0) |=> (single_out[30:0] == '0));
endmodule

// File: tb/h2s_convert_tb.sv
module h2s_convert_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // {ieee_sel, half, expected single, expected invalid}
  localparam logic [49:0] VECS [NVEC] = '{
    {1'b1, 16'h3C00, 32'h3F800000, 1'b0},
    {1'b1, 16'hC000, 32'hC0000000, 1'b0},
    {1'b1, 16'h7BFF, 32'h477FE000, 1'b0},
    {1'b1, 16'h0001, 32'h33800000, 1'b0},
    {1'b1, 16'h03FF, 32'h387FC000, 1'b0},
    {1'b1, 16'h0400, 32'h38800000, 1'b0},
    {1'b1, 16'h8000, 32'h80000000, 1'b0},
    {1'b1, 16'h7C00, 32'h7F800000, 1'b0},
    {1'b1, 16'hFC00, 32'hFF800000, 1'b0},
    {1'b1, 16'h7E00, 32'h7FC00000, 1'b0},
    {1'b1, 16'h7C01, 32'h7FC02000, 1'b1},
    {1'b1, 16'hFD55, 32'hFFEAA000, 1'b1},
    {1'b0, 16'h7C00, 32'h47800000, 1'b0},
    {1'b0, 16'h7FFF, 32'h47FFE000, 1'b0},
    {1'b0, 16'hFE00, 32'hC7C00000, 1'b0},
    {1'b0, 16'h3C00, 32'h3F800000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half_in = '0;
  logic        ieee_sel = 1'b1;
  logic [31:0] single_out;
  logic        invalid_out;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  h2s_convert dut_i (
    .clk (clk), .rst_n (rst_n), .half_in (half_in), .ieee_sel (ieee_sel),
    .single_out (single_out), .invalid_out (invalid_out)
  );

  // Behavioural model: subnormals normalized one shift at a time.
  function automatic logic [32:0] model(input logic m, input logic [15:0] h);
    logic s; logic [4:0] e; logic [10:0] f; logic [7:0] se;
    s = h[15]; e = h[14:10]; f = {1'b0, h[9:0]};
    if (m && e == 5'd31 && f == 0) return {s, 8'hFF, 23'd0, 1'b0};
    if (m && e == 5'd31) return {s, 8'hFF, 1'b1, f[8:0], 13'd0, ~f[9]};
    if (e == 0 && f == 0) return {s, 31'd0, 1'b0};
    if (e == 0) begin
      se = 8'd113;
      while (!f[10]) begin f = f << 1; se = se - 8'd1; end
      return {s, se, f[9:0], 13'd0, 1'b0};
    end
    return {s, 8'(e) + 8'd112, f[9:0], 13'd0, 1'b0};
  endfunction

  function automatic string tag(input logic m, input logic [15:0] h);
    if (h[14:10] == 5'd31 && m) return (h[9:0] == 0) ? "R3" : (h[9] ? "R4" : "R5");
    if (h[14:10] == 5'd31) return "R6";
    if (h[14:10] == 0) return (h[9:0] == 0) ? "R2" : "R7";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp,
                       input logic gi, input logic ei);
    checks++;
    if (got !== exp || gi !== ei) begin
      failures++;
      $display("FAIL %s: got %h inv=%b expected %h inv=%b", req, got, gi, exp, ei);
    end
  endtask

  task automatic apply(input logic m, input logic [15:0] h);
    @(negedge clk);
    half_in = h; ieee_sel = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [32:0] r;
    // R8: reset holds outputs at zero even with a NaN-producing input.
    half_in = 16'h7C01; ieee_sel = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R8 reset", single_out, 32'h0, invalid_out, 1'b0);
    @(negedge clk); rst_n = 1'b1; half_in = 16'h0000;
    @(posedge clk); #1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][49], VECS[i][48:33]);
      check({"table ", tag(VECS[i][49], VECS[i][48:33])}, single_out, VECS[i][32:1],
            invalid_out, VECS[i][0]);
    end

    // R8: output holds until the next rising edge.
    apply(1'b1, 16'h3C00);
    @(negedge clk); half_in = 16'hC000; #1;
    check("R8 hold", single_out, 32'h3F800000, invalid_out, 1'b0);
    @(posedge clk); #1;
    check("R8 latency", single_out, 32'hC0000000, invalid_out, 1'b0);

    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 65536; v++) begin
        apply(m[0], v[15:0]);
        r = model(m[0], v[15:0]);
        check({"exhaustive ", tag(m[0], v[15:0])}, single_out, r[32:1], invalid_out, r[0]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule